// File: doc/BRIEF.md
# Configurable Sum-Term Storage and Output Cell Bank

This block is the storage and output stage behind a programmable AND/OR logic array. Each cell receives one data sum term and one enable/clock sum term from the array. Each cell is configured on its own to act in one of three ways:

- as a purely combinational path;
- as a D register on the shared output clock, using the second sum term as a clock enable;
- as a D register clocked directly by its own second sum term.

Polarity stages invert the enable/clock term on every cell and the data term on cells that reach a pin. An active-high asynchronous clear term, shared by all cells, zeroes every register. Power-on reset does the same.

The bank holds two groups of cells. Output cells drive a pin through an inverting driver with its own output-enable term. They expose two feedback values: the internal value taken before the driver, and the pin value as seen through the input path. With the driver off, the pin can therefore act as an input. Buried cells only feed back. A test preload port forces chosen values into every register on the output clock, whatever the mode. The array and the pads are outside the block.

Top module: `sumterm_cell_bank`

## Requirements
- R1: With `cfg_reg[i]`=0 the cell is combinational: `core_fb[i]` equals the effective data term at once, with no clock edge.
- R2: With `cfg_reg[i]`=1 and `cfg_stclk[i]`=0, the register takes the effective data term on a rising `oclk` edge when the effective enable term is 1.
- R3: In the mode of R2, a rising `oclk` edge with the effective enable term at 0 leaves the register unchanged.
- R4: With `cfg_reg[i]`=1 and `cfg_stclk[i]`=1, the register takes the effective data term on each rising edge of the effective enable term, and `oclk` edges do not change it.
- R5: The effective enable term is `e_term[i]` XOR `cfg_epol[i]` on every cell, so with `cfg_epol[i]`=1 a low `e_term` enables or clocks the register.
- R6: The effective data term is `d_term[i]` XOR `cfg_dpol[i]` on output cells (indices 0 to N_OUT-1). Buried cells (indices N_OUT and up) use `d_term` unchanged.
- R7: While `arst` is 1, every register reads 0 without waiting for a clock edge, and rising edges are ignored. An enabled pin of a registered output cell then reads 1.
- R8: While `rst_n` is 0 every register is 0. Release is synchronised to `oclk` over two stages.
- R9: `pad_oe[i]` follows `oe_pt[i]`, and `pad_out[i]` is the inverse of `core_fb[i]`.
- R10: `pin_fb[i]` equals `pad_out[i]` when the driver is enabled and `pad_in[i]` when it is disabled. `pad_in` never affects `core_fb`.
- R11: With `test_load`=1, a rising `oclk` edge loads `test_val[i]` into every register, whatever the mode or enable term. The clock of a sum-term-clocked cell is switched to `oclk` while `test_load` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oclk | input | 1 | Shared output clock |
| rst_n | input | 1 | Active-low power-on reset |
| arst | input | 1 | Active-high asynchronous clear term for all registers |
| test_load | input | 1 | Preload strobe |
| test_val | input | N_CELLS | Preload values, bit i for cell i |
| d_term | input | N_CELLS | Data sum terms |
| e_term | input | N_CELLS | Enable/clock sum terms |
| oe_pt | input | N_OUT | Output-enable product terms |
| pad_in | input | N_OUT | Value seen on each output pin by the input path |
| cfg_reg | input | N_CELLS | 1 = registered, 0 = combinational |
| cfg_stclk | input | N_CELLS | 1 = sum-term clock, 0 = shared clock with enable |
| cfg_epol | input | N_CELLS | Enable/clock term inversion |
| cfg_dpol | input | N_OUT | Data term inversion, output cells only |
| pad_out | output | N_OUT | Inverting driver data |
| pad_oe | output | N_OUT | Driver enable |
| pin_fb | output | N_OUT | Pin-side feedback |
| core_fb | output | N_CELLS | Internal feedback before the driver |

## Verification
The assertions check the following on every shared-clock edge:

- shared-clock load and hold, including polarity;
- preload capture;
- registers reading zero under the clear term;
- enabled registered pins reading one during power-on reset.

Sum-term clocking has no relation to `oclk` that a clocked property can state, so only the bench scenarios show it: mid-cycle enable edges, loads with no `oclk` edge, and the inverted-polarity falling edge. The same holds for the driver-off pin feedback path and for the asynchronous effect of the clear term between edges.

// File: rtl/sumterm_cell_pkg.sv
package sumterm_cell_pkg;

  typedef enum logic [1:0] {
    MODE_COMB  = 2'd0,
    MODE_CE    = 2'd1,
    MODE_STCLK = 2'd2
  } cell_mode_t;

  typedef struct packed {
    logic reg_en;
    logic stclk;
    logic epol;
    logic dpol;
  } cell_cfg_t;

  function automatic cell_mode_t decode_mode(cell_cfg_t c);
    if (!c.reg_en)   return MODE_COMB;
    else if (c.stclk) return MODE_STCLK;
    else              return MODE_CE;
  endfunction

endpackage

// File: rtl/stc_rst_sync.sv
module stc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/stc_cell.sv
module stc_cell
  import sumterm_cell_pkg::*;
#(
  parameter bit HAS_DPOL = 1'b1
) (
  input  logic      oclk,
  input  logic      clr,
  input  logic      test_load,
  input  logic      test_val,
  input  logic      d_term,
  input  logic      e_term,
  input  cell_cfg_t cfg,
  output logic      core_q
);
  localparam logic DPOL_MASK = HAS_DPOL;

  cell_mode_t mode;
  logic d_eff;
  logic e_eff;
  logic cell_clk;
  logic load_en;
  logic q;
  logic q_nxt;

  always_comb begin
    mode  = decode_mode(cfg);
    d_eff = d_term ^ (cfg.dpol & DPOL_MASK);
    e_eff = e_term ^ cfg.epol;
  end

  // clock select: sum-term clock unless preloading
  always_comb begin
    if ((mode == MODE_STCLK) && !test_load) cell_clk = e_eff;
    else                                    cell_clk = oclk;
  end

  // next state with explicit enable
  always_comb begin
    load_en = test_load | (mode == MODE_STCLK) | e_eff;
    if (test_load)    q_nxt = test_val;
    else if (load_en) q_nxt = d_eff;
    else              q_nxt = q;
  end

  always_ff @(posedge cell_clk or posedge clr) begin
    if (clr) q <= 1'b0;
    else     q <= q_nxt;
  end

  assign core_q = (mode == MODE_COMB) ? d_eff : q;

  AST_CE_LOAD: assert property (@(posedge oclk) disable iff (clr)
    ((mode == MODE_CE) && !test_load && e_eff) |=> (q == $past(d_eff))) // R2
    else $error("AST_CE_LOAD");

  AST_CE_HOLD: assert property (@(posedge oclk) disable iff (clr)
    ((mode == MODE_CE) && !test_load && !e_eff) |=> $stable(q)) // R3
    else $error("AST_CE_HOLD");

  AST_PRELOAD: assert property (@(posedge oclk) disable iff (clr)
    test_load |=> (q == $past(test_val))) // R11
    else $error("AST_PRELOAD");

endmodule

// File: rtl/stc_pin.sv
module stc_pin (
  input  logic core_q,
  input  logic oe_pt,
  input  logic pad_in,
  output logic pad_out,
  output logic pad_oe,
  output logic pin_fb
);
  always_comb begin
    pad_out = ~core_q;
    pad_oe  = oe_pt;
    pin_fb  = oe_pt ? pad_out : pad_in;
  end
endmodule

// File: rtl/sumterm_cell_bank.sv
module sumterm_cell_bank
  import sumterm_cell_pkg::*;
#(
  parameter int N_OUT = 4,
  parameter int N_BUR = 2,
  localparam int N_CELLS = N_OUT + N_BUR
) (
  input  logic               oclk,
  input  logic               rst_n,
  input  logic               arst,
  input  logic               test_load,
  input  logic [N_CELLS-1:0] test_val,
  input  logic [N_CELLS-1:0] d_term,
  input  logic [N_CELLS-1:0] e_term,
  input  logic [N_OUT-1:0]   oe_pt,
  input  logic [N_OUT-1:0]   pad_in,
  input  logic [N_CELLS-1:0] cfg_reg,
  input  logic [N_CELLS-1:0] cfg_stclk,
  input  logic [N_CELLS-1:0] cfg_epol,
  input  logic [N_OUT-1:0]   cfg_dpol,
  output logic [N_OUT-1:0]   pad_out,
  output logic [N_OUT-1:0]   pad_oe,
  output logic [N_OUT-1:0]   pin_fb,
  output logic [N_CELLS-1:0] core_fb
);
  logic rst_s;
  logic clr;

  stc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (oclk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_s)
  );

  assign clr = arst | ~rst_s;

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    cell_cfg_t cfg_i;
    assign cfg_i = '{reg_en: cfg_reg[i], stclk: cfg_stclk[i],
                     epol: cfg_epol[i], dpol: cfg_dpol[i]};

    stc_cell #(.HAS_DPOL(1'b1)) u_cell (
      .oclk      (oclk),
      .clr       (clr),
      .test_load (test_load),
      .test_val  (test_val[i]),
      .d_term    (d_term[i]),
      .e_term    (e_term[i]),
      .cfg       (cfg_i),
      .core_q    (core_fb[i])
    );

    stc_pin u_pin (
      .core_q  (core_fb[i]),
      .oe_pt   (oe_pt[i]),
      .pad_in  (pad_in[i]),
      .pad_out (pad_out[i]),
      .pad_oe  (pad_oe[i]),
      .pin_fb  (pin_fb[i])
    );
  end

  for (genvar j = 0; j < N_BUR; j++) begin : g_bur
    localparam int K = N_OUT + j;
    cell_cfg_t cfg_j;
    assign cfg_j = '{reg_en: cfg_reg[K], stclk: cfg_stclk[K],
                     epol: cfg_epol[K], dpol: 1'b0};

    stc_cell #(.HAS_DPOL(1'b0)) u_cell (
      .oclk      (oclk),
      .clr       (clr),
      .test_load (test_load),
      .test_val  (test_val[K]),
      .d_term    (d_term[K]),
      .e_term    (e_term[K]),
      .cfg       (cfg_j),
      .core_q    (core_fb[K])
    );
  end

  AST_CLR_ZERO: assert property (@(posedge oclk) disable iff (!rst_n)
    arst |-> ((core_fb & cfg_reg) == '0)) // R7
    else $error("AST_CLR_ZERO");

  AST_PWRUP_PIN_HIGH: assert property (@(posedge oclk) disable iff (arst)
    !rst_s |-> (((~pad_out) & pad_oe & cfg_reg[N_OUT-1:0]) == '0)) // R8
    else $error("AST_PWRUP_PIN_HIGH");

endmodule

// File: tb/sumterm_cell_bank_tb.sv
module sumterm_cell_bank_tb;
  localparam int  N_OUT   = 4;
  localparam int  N_BUR   = 2;
  localparam int  N_CELLS = N_OUT + N_BUR;
  localparam time CLK_PERIOD = 10ns;

  logic               oclk = 1'b0;
  logic               rst_n, arst, test_load;
  logic [N_CELLS-1:0] test_val, d_term, e_term, cfg_reg, cfg_stclk, cfg_epol;
  logic [N_OUT-1:0]   oe_pt, pad_in, cfg_dpol;
  logic [N_OUT-1:0]   pad_out, pad_oe, pin_fb;
  logic [N_CELLS-1:0] core_fb;

  typedef enum int {K_CORE, K_PAD, K_OE, K_PINFB} sig_kind_t;
  typedef struct {
    string     req;
    sig_kind_t kind;
    int        idx;
    logic      exp;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) oclk = ~oclk;

  sumterm_cell_bank #(.N_OUT(N_OUT), .N_BUR(N_BUR)) u_dut (
    .oclk(oclk), .rst_n(rst_n), .arst(arst), .test_load(test_load),
    .test_val(test_val), .d_term(d_term), .e_term(e_term), .oe_pt(oe_pt),
    .pad_in(pad_in), .cfg_reg(cfg_reg), .cfg_stclk(cfg_stclk),
    .cfg_epol(cfg_epol), .cfg_dpol(cfg_dpol), .pad_out(pad_out),
    .pad_oe(pad_oe), .pin_fb(pin_fb), .core_fb(core_fb)
  );

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      sb_item_t it;
      logic act;
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      case (it.kind)
        K_CORE:  act = core_fb[it.idx];
        K_PAD:   act = pad_out[it.idx];
        K_OE:    act = pad_oe[it.idx];
        default: act = pin_fb[it.idx];
      endcase
      n_checks++;
      if (act !== it.exp) begin
        n_errors++;
        $display("FAIL %s kind=%0d idx=%0d actual=%b expected=%b",
                 it.req, it.kind, it.idx, act, it.exp);
      end
    end
  end

  task automatic expect_sig(string req, sig_kind_t kind, int idx, logic exp);
    sb_item_t it;
    it.req = req; it.kind = kind; it.idx = idx; it.exp = exp;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic tick();
    @(negedge oclk);
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    // cells: 0 comb, 1 comb inverted D, 2 shared-clock CE, 3 sum-term clock,
    // 4 buried CE inverted E, 5 buried sum-term clock inverted E
    cfg_reg = 6'b111100; cfg_stclk = 6'b101000;
    cfg_epol = 6'b110000; cfg_dpol = 4'b0010;
    rst_n = 1'b0; arst = 1'b0; test_load = 1'b0; test_val = '0;
    d_term = '0; e_term = '0; oe_pt = '1; pad_in = '0;
    repeat (3) tick();
    #2;
    for (int c = 2; c < N_CELLS; c++) expect_sig("R8", K_CORE, c, 1'b0);
    expect_sig("R8", K_PAD, 2, 1'b1);
    expect_sig("R8", K_PAD, 3, 1'b1);
    rst_n = 1'b1;
    repeat (3) tick();
    #2 expect_sig("R8", K_CORE, 4, 1'b0);

    // R1 / R6 / R9 combinational paths
    d_term[0] = 1'b1; d_term[1] = 1'b1;
    #2;
    expect_sig("R1", K_CORE, 0, 1'b1);
    expect_sig("R6", K_CORE, 1, 1'b0);
    expect_sig("R9", K_PAD, 0, 1'b0);
    expect_sig("R9", K_PAD, 1, 1'b1);
    tick(); d_term[0] = 1'b0; d_term[1] = 1'b0;
    #2;
    expect_sig("R1", K_CORE, 0, 1'b0);
    expect_sig("R6", K_CORE, 1, 1'b1);

    // R2 load with enable
    tick(); d_term[2] = 1'b1; e_term[2] = 1'b1;
    #2 expect_sig("R2", K_CORE, 2, 1'b0);
    tick(); #2 expect_sig("R2", K_CORE, 2, 1'b1);
    // R3 hold without enable
    e_term[2] = 1'b0; d_term[2] = 1'b0;
    tick(); tick(); #2 expect_sig("R3", K_CORE, 2, 1'b1);
    e_term[2] = 1'b1;
    tick(); #2 expect_sig("R2", K_CORE, 2, 1'b0);
    d_term[2] = 1'b1;
    tick(); #2 expect_sig("R2", K_CORE, 2, 1'b1);
    e_term[2] = 1'b0;

    // R4 sum-term clock
    d_term[3] = 1'b1;
    tick(); tick(); #2 expect_sig("R4", K_CORE, 3, 1'b0);
    e_term[3] = 1'b1;
    #2 expect_sig("R4", K_CORE, 3, 1'b1);
    d_term[3] = 1'b0;
    tick(); e_term[3] = 1'b0;
    #2 expect_sig("R4", K_CORE, 3, 1'b1);
    tick(); #2 expect_sig("R4", K_CORE, 3, 1'b1);
    e_term[3] = 1'b1;
    #2 expect_sig("R4", K_CORE, 3, 1'b0);
    e_term[3] = 1'b0; d_term[3] = 1'b1;
    #2 e_term[3] = 1'b1;
    #2 expect_sig("R4", K_CORE, 3, 1'b1);
    e_term[3] = 1'b0;

    // R5 inverted enable polarity
    tick(); d_term[4] = 1'b1;
    tick(); #2 expect_sig("R5", K_CORE, 4, 1'b1);
    e_term[4] = 1'b1; d_term[4] = 1'b0;
    tick(); tick(); #2 expect_sig("R5", K_CORE, 4, 1'b1);
    d_term[5] = 1'b1; e_term[5] = 1'b1;
    #2 expect_sig("R5", K_CORE, 5, 1'b0);
    e_term[5] = 1'b0;
    #2 expect_sig("R5", K_CORE, 5, 1'b1);

    // R7 asynchronous clear
    tick(); arst = 1'b1;
    #2;
    for (int c = 2; c < N_CELLS; c++) expect_sig("R7", K_CORE, c, 1'b0);
    expect_sig("R7", K_PAD, 2, 1'b1);
    expect_sig("R7", K_PAD, 3, 1'b1);
    e_term[2] = 1'b1; d_term[2] = 1'b1;
    tick(); #2 expect_sig("R7", K_CORE, 2, 1'b0);
    arst = 1'b0;
    tick(); #2 expect_sig("R2", K_CORE, 2, 1'b1);

    // R9 / R10 driver off, pin feedback
    oe_pt[0] = 1'b0; d_term[0] = 1'b1; pad_in[0] = 1'b1;
    #2;
    expect_sig("R9", K_OE, 0, 1'b0);
    expect_sig("R10", K_PINFB, 0, 1'b1);
    expect_sig("R10", K_CORE, 0, 1'b1);
    pad_in[0] = 1'b0;
    #2;
    expect_sig("R10", K_PINFB, 0, 1'b0);
    expect_sig("R10", K_CORE, 0, 1'b1);
    pad_in[0] = 1'b1; oe_pt[0] = 1'b1;
    #2;
    expect_sig("R9", K_OE, 0, 1'b1);
    expect_sig("R10", K_PINFB, 0, 1'b0);

    // R11 preload regardless of mode
    tick(); e_term[2] = 1'b0; e_term[3] = 1'b0; e_term[5] = 1'b1;
    test_val = 6'b101010; test_load = 1'b1;
    tick(); test_load = 1'b0;
    #2;
    expect_sig("R11", K_CORE, 2, 1'b0);
    expect_sig("R11", K_CORE, 3, 1'b1);
    expect_sig("R11", K_CORE, 4, 1'b0);
    expect_sig("R11", K_CORE, 5, 1'b1);
    expect_sig("R11", K_CORE, 1, 1'b1);
    tick(); tick(); #2;
    expect_sig("R11", K_CORE, 3, 1'b1);
    expect_sig("R11", K_CORE, 5, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule